// File: doc/BRIEF.md
# Dual-Edge Sample Stream Interleaver

This block sits behind the parallel byte buses of a dual-channel data converter and puts the samples back into time order. Each lane group has four lanes of `DW` bits. Two of them, `lane_di` and `lane_dq`, are the newer samples. The other two, `lane_did` and `lane_dqd`, are the delayed copies. A one-cycle `lane_vld` strobe marks each lane group. The mode inputs describe how the converter was set up: separate channels or dual-edge sampling, with or without the 1:2 lane demultiplexing, and which channel feeds a dual-edge run.

In separate-channel mode the block emits one I stream and one Q stream, one sample per clock on each. In dual-edge mode it emits a single stream, one sample per clock, with a channel tag. The mode is taken only at a group boundary. The first group that arrives under a new mode is discarded while the block switches over. Upstream logic must space `lane_vld` pulses at least as far apart as the number of samples each group yields. A group may arrive in the cycle that emits the last sample of the previous group, and the stream then continues without a gap.

Top module: `dual_edge_interleaver`

## Requirements
- R1: After reset, `i_vld`, `q_vld` and `s_vld` are low, and the current mode is separate-channel, non-demux, I channel.
- R2: In dual-edge mode with demux on, an accepted group emits four samples on `s_data` in consecutive cycles, starting the cycle after `lane_vld`. The order is `lane_dqd`, `lane_did`, `lane_dq`, `lane_di`.
- R3: In dual-edge mode with demux off, an accepted group emits `lane_dq` and then `lane_di` on `s_data` in consecutive cycles, starting the cycle after `lane_vld`.
- R4: With demux off, in either sampling mode, the values on `lane_did` and `lane_dqd` never reach any output.
- R5: In separate-channel mode with demux on, an accepted group emits `lane_did` and then `lane_di` on the I stream. It emits `lane_dqd` and then `lane_dq` on the Q stream in the same two cycles, starting the cycle after `lane_vld`.
- R6: In separate-channel mode with demux off, an accepted group emits `lane_di` on `i_data` and `lane_dq` on `q_data` for one cycle, starting the cycle after `lane_vld`.
- R7: `s_tag` is 1 (Q channel) only when both `chan_sel_q` and `ext_ctrl_en` were high for the group. Otherwise it is 0 (I channel).
- R8: The mode inputs are sampled only with `lane_vld`. A group whose mode differs from the current mode is discarded and becomes the new current mode. No output valid is high in the following cycle.
- R9: In dual-edge mode `i_vld` and `q_vld` stay low. In separate-channel mode `s_vld` stays low.
- R10: A group arriving in the cycle that emits the last sample of the previous group continues the stream with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_vld | input | 1 | Marks a lane group |
| lane_di | input | DW | Newest falling-edge lane |
| lane_did | input | DW | Delayed falling-edge lane |
| lane_dq | input | DW | Newest second lane |
| lane_dqd | input | DW | Delayed second lane |
| mode_dual | input | 1 | 1 = dual-edge sampling, 0 = separate channels |
| mode_demux | input | 1 | 1 = four-lane demux, 0 = two lanes |
| chan_sel_q | input | 1 | Select Q channel in dual-edge mode |
| ext_ctrl_en | input | 1 | Allows Q selection |
| i_data | output | DW | I-channel sample |
| i_vld | output | 1 | I sample valid |
| q_data | output | DW | Q-channel sample |
| q_vld | output | 1 | Q sample valid |
| s_data | output | DW | Dual-edge serial sample |
| s_vld | output | 1 | Serial sample valid |
| s_tag | output | 1 | Channel of serial stream, 1 = Q |

## Verification
The hardest case to reach from the ports is a mode switch that coincides with a group boundary. Mode changes that do not arrive with `lane_vld` have no visible effect, so the switch only shows at that boundary. The bench sweeps every mode in sequence, including a change of the channel tag alone. Each new mode is opened with a sacrificial group whose discard is checked the following cycle. Then a ramp is driven at the tightest allowed group spacing, and one run uses a looser spacing. The output must count up exactly while the unused lanes carry values that would break the count if they leaked.

// File: rtl/dei_pkg.sv
// Package: shared mode type and slot counts for the interleaver.
// Assumes lane groups hold at most four samples.
package dei_pkg;
    localparam int DUAL_SLOTS = 4;
    localparam int SEP_SLOTS  = 2;
    localparam int DCW = $clog2(DUAL_SLOTS + 1);
    localparam int SCW = $clog2(SEP_SLOTS + 1);

    typedef struct packed {
        logic dual;    // dual-edge sampling
        logic demux;   // four-lane groups
        logic chan_q;  // Q channel feeds dual-edge stream
    } dei_mode_t;
endpackage

// File: rtl/dei_mode_ctl.sv
// Mode control: samples the mode inputs with each lane group and keeps
// the current mode. A group arriving under a different mode is dropped
// and that mode becomes current. Q selection requires extended control.
module dei_mode_ctl
    import dei_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lane_vld,
    input  logic      mode_dual,
    input  logic      mode_demux,
    input  logic      chan_sel_q,
    input  logic      ext_ctrl_en,
    output dei_mode_t mode_in,
    output dei_mode_t mode_cur,
    output logic      accept,
    output logic      drop
);
    // Effective incoming mode; channel only meaningful in dual-edge mode.
    always_comb begin
        mode_in.dual   = mode_dual;
        mode_in.demux  = mode_demux;
        mode_in.chan_q = mode_dual & chan_sel_q & ext_ctrl_en;
    end

    // Accept or drop the group presented with lane_vld.
    always_comb begin
        accept = lane_vld && (mode_in == mode_cur);
        drop   = lane_vld && (mode_in != mode_cur);
    end

    // Current mode register, updated only by a dropped group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_cur <= '0;
        end else if (drop) begin
            mode_cur <= mode_in;
        end
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (mode_cur == $past(mode_cur)));
endmodule

// File: rtl/dei_slot_map.sv
// Slot map: places the lanes of one group into emission slots, earliest
// first, for the incoming mode. Unused lanes never enter a slot.
module dei_slot_map
    import dei_pkg::*;
#(
    parameter int DW = 7
) (
    input  dei_mode_t                      mode_in,
    input  logic [DW-1:0]                  lane_di,
    input  logic [DW-1:0]                  lane_did,
    input  logic [DW-1:0]                  lane_dq,
    input  logic [DW-1:0]                  lane_dqd,
    output logic [DUAL_SLOTS-1:0][DW-1:0]  s_slots,
    output logic [DCW-1:0]                 s_cnt,
    output logic [SEP_SLOTS-1:0][DW-1:0]   i_slots,
    output logic [SCW-1:0]                 i_cnt,
    output logic [SEP_SLOTS-1:0][DW-1:0]   q_slots,
    output logic [SCW-1:0]                 q_cnt
);
    // Dual-edge stream: rising-edge lane precedes falling-edge lane.
    always_comb begin
        s_slots = '0;
        s_cnt   = '0;
        if (mode_in.dual) begin
            if (mode_in.demux) begin
                s_slots[0] = lane_dqd;
                s_slots[1] = lane_did;
                s_slots[2] = lane_dq;
                s_slots[3] = lane_di;
                s_cnt      = DCW'(4);
            end else begin
                s_slots[0] = lane_dq;
                s_slots[1] = lane_di;
                s_cnt      = DCW'(2);
            end
        end
    end

    // Separate channels: delayed lane is one clock older.
    always_comb begin
        i_slots = '0;
        q_slots = '0;
        i_cnt   = '0;
        q_cnt   = '0;
        if (!mode_in.dual) begin
            if (mode_in.demux) begin
                i_slots[0] = lane_did;
                i_slots[1] = lane_di;
                q_slots[0] = lane_dqd;
                q_slots[1] = lane_dq;
                i_cnt      = SCW'(2);
                q_cnt      = SCW'(2);
            end else begin
                i_slots[0] = lane_di;
                q_slots[0] = lane_dq;
                i_cnt      = SCW'(1);
                q_cnt      = SCW'(1);
            end
        end
    end
endmodule

// File: rtl/dei_serializer.sv
// Serializer: holds up to N samples and emits slot 0 first, one per
// clock. Assumes a new load arrives only when at most one sample is left.
module dei_serializer #(
    parameter int DW = 7,
    parameter int N  = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [CW-1:0]        load_cnt,
    input  logic [N-1:0][DW-1:0] slots,
    output logic [DW-1:0]        out_data,
    output logic                 out_vld
);
    logic [N-1:0][DW-1:0] hold_q;
    logic [CW-1:0]        left_q;

    // Load a new group or shift the next sample to the head.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            left_q <= '0;
        end else if (load && (load_cnt != '0)) begin
            hold_q <= slots;
            left_q <= load_cnt;
        end else if (left_q != '0) begin
            hold_q <= {{DW{1'b0}}, hold_q[N-1:1]};
            left_q <= left_q - 1'b1;
        end
    end

    // Head of the holding register drives the output.
    always_comb begin
        out_data = hold_q[0];
        out_vld  = (left_q != '0);
    end

    // R10
    no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && (load_cnt != '0)) |-> (left_q <= CW'(1)));
    // R10
    drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == CW'(1) && !load) |=> !out_vld);
endmodule

// File: rtl/dual_edge_interleaver.sv
// Top: restores time order of converter lane groups. Separate-channel
// mode feeds the I and Q serializers; dual-edge mode feeds the single
// tagged stream. Assumes lane_vld spacing of at least the group size.
module dual_edge_interleaver
    import dei_pkg::*;
#(
    parameter int DW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lane_vld,
    input  logic [DW-1:0] lane_di,
    input  logic [DW-1:0] lane_did,
    input  logic [DW-1:0] lane_dq,
    input  logic [DW-1:0] lane_dqd,
    input  logic          mode_dual,
    input  logic          mode_demux,
    input  logic          chan_sel_q,
    input  logic          ext_ctrl_en,
    output logic [DW-1:0] i_data,
    output logic          i_vld,
    output logic [DW-1:0] q_data,
    output logic          q_vld,
    output logic [DW-1:0] s_data,
    output logic          s_vld,
    output logic          s_tag
);
    dei_mode_t mode_in, mode_cur;
    logic      accept, drop;

    logic [DUAL_SLOTS-1:0][DW-1:0] s_slots;
    logic [SEP_SLOTS-1:0][DW-1:0]  i_slots, q_slots;
    logic [DCW-1:0]                s_cnt;
    logic [SCW-1:0]                i_cnt, q_cnt;

    dei_mode_ctl u_mode (
        .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld),
        .mode_dual(mode_dual), .mode_demux(mode_demux),
        .chan_sel_q(chan_sel_q), .ext_ctrl_en(ext_ctrl_en),
        .mode_in(mode_in), .mode_cur(mode_cur),
        .accept(accept), .drop(drop)
    );

    dei_slot_map #(.DW(DW)) u_map (
        .mode_in(mode_in), .lane_di(lane_di), .lane_did(lane_did),
        .lane_dq(lane_dq), .lane_dqd(lane_dqd),
        .s_slots(s_slots), .s_cnt(s_cnt),
        .i_slots(i_slots), .i_cnt(i_cnt),
        .q_slots(q_slots), .q_cnt(q_cnt)
    );

    dei_serializer #(.DW(DW), .N(DUAL_SLOTS)) u_ser_s (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_cnt(s_cnt),
        .slots(s_slots), .out_data(s_data), .out_vld(s_vld)
    );

    dei_serializer #(.DW(DW), .N(SEP_SLOTS)) u_ser_i (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_cnt(i_cnt),
        .slots(i_slots), .out_data(i_data), .out_vld(i_vld)
    );

    dei_serializer #(.DW(DW), .N(SEP_SLOTS)) u_ser_q (
        .clk(clk), .rst_n(rst_n), .load(accept), .load_cnt(q_cnt),
        .slots(q_slots), .out_data(q_data), .out_vld(q_vld)
    );

    // Channel tag follows the current mode.
    always_comb s_tag = mode_cur.chan_q;

    // R9
    stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(s_vld && (i_vld || q_vld)));
    // R8
    drop_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !(s_vld || i_vld || q_vld));
    // R7
    tag_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !(chan_sel_q && ext_ctrl_en)) |=> !s_tag);
endmodule

// File: tb/test_dual_edge_interleaver.sv
module test_dual_edge_interleaver;
    localparam int DW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lane_vld = 1'b0;
    logic [DW-1:0] lane_di = '0, lane_did = '0, lane_dq = '0, lane_dqd = '0;
    logic          mode_dual = 1'b0, mode_demux = 1'b0;
    logic          chan_sel_q = 1'b0, ext_ctrl_en = 1'b0;
    logic [DW-1:0] i_data, q_data, s_data;
    logic          i_vld, q_vld, s_vld, s_tag;

    int errors = 0, checks = 0;
    int exp_s, exp_i, exp_q, n_s, n_i, n_q, wrong;
    bit mon_en = 1'b0, cur_dual = 1'b0, cur_tag = 1'b0;
    bit [2:0] cur_mode = 3'b000;
    string cur_req = "R6";

    always #2 clk = ~clk;

    dual_edge_interleaver #(.DW(DW)) i_dual_edge_interleaver (
        .clk(clk), .rst_n(rst_n), .lane_vld(lane_vld),
        .lane_di(lane_di), .lane_did(lane_did), .lane_dq(lane_dq),
        .lane_dqd(lane_dqd), .mode_dual(mode_dual), .mode_demux(mode_demux),
        .chan_sel_q(chan_sel_q), .ext_ctrl_en(ext_ctrl_en),
        .i_data(i_data), .i_vld(i_vld), .q_data(q_data), .q_vld(q_vld),
        .s_data(s_data), .s_vld(s_vld), .s_tag(s_tag)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: every emitted sample must equal the next ramp value.
    always @(negedge clk) begin
        if (mon_en) begin
            if (s_vld) begin
                if (!cur_dual) wrong++;
                chk(s_data == DW'(exp_s), cur_req, s_data, exp_s);
                chk(s_tag == cur_tag, "R7", s_tag, cur_tag);
                exp_s++; n_s++;
            end
            if (i_vld) begin
                if (cur_dual) wrong++;
                chk(i_data == DW'(exp_i), cur_req, i_data, exp_i);
                exp_i++; n_i++;
            end
            if (q_vld) begin
                if (cur_dual) wrong++;
                chk(q_data == DW'(exp_q), cur_req, q_data, exp_q);
                exp_q++; n_q++;
            end
        end
    end

    task automatic run(input bit d, input bit dm, input bit cs, input bit ex,
                       input int sp, input int grp, input string req);
        bit [2:0] m;
        int slots;
        m = {d, dm, d & cs & ex};
        slots = dm ? (d ? 4 : 2) : (d ? 2 : 1);
        @(negedge clk);
        mode_dual = d; mode_demux = dm; chan_sel_q = cs; ext_ctrl_en = ex;
        if (m != cur_mode) begin
            lane_di = 7'd5; lane_did = 7'd6; lane_dq = 7'd7; lane_dqd = 7'd8;
            lane_vld = 1'b1;
            @(negedge clk);
            lane_vld = 1'b0;
            chk(!(s_vld || i_vld || q_vld), "R8", {s_vld, i_vld, q_vld}, 0);
            cur_mode = m;
        end
        cur_dual = d; cur_tag = m[0]; cur_req = req;
        exp_s = 0; exp_i = 0; exp_q = 64; n_s = 0; n_i = 0; n_q = 0; wrong = 0;
        mon_en = 1'b1;
        for (int g = 0; g < grp; g++) begin
            if (d && dm) begin
                lane_dqd = DW'(4*g); lane_did = DW'(4*g+1);
                lane_dq  = DW'(4*g+2); lane_di = DW'(4*g+3);
            end else if (d) begin
                lane_dq = DW'(2*g); lane_di = DW'(2*g+1);
                lane_did = DW'(100+g); lane_dqd = DW'(120-g);
            end else if (dm) begin
                lane_did = DW'(2*g); lane_di = DW'(2*g+1);
                lane_dqd = DW'(64+2*g); lane_dq = DW'(65+2*g);
            end else begin
                lane_di = DW'(g); lane_dq = DW'(64+g);
                lane_did = DW'(127-g); lane_dqd = 7'd127;
            end
            lane_vld = 1'b1;
            @(negedge clk);
            lane_vld = 1'b0;
            // Mode pins wiggle between groups without effect (R8).
            chan_sel_q = ~cs;
            repeat (sp - 1) @(negedge clk);
            chan_sel_q = cs;
        end
        repeat (6) @(negedge clk);
        mon_en = 1'b0;
        chk(n_s == (d ? slots*grp : 0), req, n_s, d ? slots*grp : 0);
        chk(n_i == (d ? 0 : slots*grp), req, n_i, d ? 0 : slots*grp);
        chk(n_q == (d ? 0 : slots*grp), req, n_q, d ? 0 : slots*grp);
        chk(wrong == 0, "R9", wrong, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(!(s_vld || i_vld || q_vld), "R1", {s_vld, i_vld, q_vld}, 0);
        run(1'b0, 1'b0, 1'b0, 1'b0, 1, 16, "R6 R4 R10");
        run(1'b0, 1'b1, 1'b0, 1'b0, 2, 8,  "R5 R10");
        run(1'b1, 1'b1, 1'b1, 1'b0, 4, 8,  "R2 R7");
        run(1'b1, 1'b1, 1'b1, 1'b1, 4, 8,  "R2 R7 R8");
        run(1'b1, 1'b0, 1'b0, 1'b1, 2, 16, "R3 R4");
        run(1'b1, 1'b0, 1'b1, 1'b1, 3, 12, "R3 R7");
        run(1'b0, 1'b0, 1'b0, 1'b0, 1, 8,  "R6 R1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule